// File: doc/BRIEF.md
# Byte-Loaded Streaming Address Port

This block lets a host with only an 8-bit data bus and three active-low strobes reach a memory of 4M bytes. The host writes the 22-bit start address one byte at a time and then pulls bytes out one after another. Each byte read moves the address forward by one. An internal byte pointer decides which part of the address a write lands in. A full load therefore takes up to three writes. Moving within a 256-byte page takes a single write, and moving within a 64 KB block takes two.

The host strobes are synchronised to the system clock and edge-detected. Write data is captured on the release (rising edge) of the write strobe. A read is a low pulse on output-enable with select bit 2 at 0. The read counter advances on the release of output-enable. The memory side is a synchronous read port with one clock of latency, and that latency is absorbed before the bus driver turns on. Accesses with select bit 2 at 1 belong to neighbouring I/O registers. This block ignores them, apart from keeping its pointer and address untouched so that an interrupted address load can resume.

Top module: `seqAddrPort`

## Requirements
- R1: After reset the memory address is 0, the bus is not driven, and the byte pointer targets the low address byte.
- R2: Address writes fill bits 7..0 first, then bits 15..8, then bits 21..16. Each write takes the bus byte present when the write strobe is released, and then the pointer moves on.
- R3: While select bit 2 is 0, select bits 1 and 0 have no effect on writes or reads.
- R4: The top lane holds only 6 bits, and the upper two bus bits are dropped. Once the top lane has been written, further writes keep landing in it until the pointer is cleared.
- R5: A write to the low lane leaves address bits 21..8 unchanged.
- R6: A ROM read (output-enable low, select bit 2 at 0) returns the pointer to the low lane.
- R7: Holding chip-enable high returns the pointer to the low lane.
- R8: With select bit 2 at 1, writes and reads change neither the pointer, the address nor the bus enable. An address load interrupted by such accesses resumes at the lane where it stopped.
- R9: During a ROM read the bus carries the memory byte at the current address. The address increments by one when output-enable is released.
- R10: Incrementing from 0x3FFFFF gives 0.
- R11: The bus enable is low whenever chip-enable or output-enable is high.
- R12: With chip-enable high, write and output-enable strobes change neither the address nor the bus.
- R13: If a write-strobe release and an output-enable release are detected in the same clock, the byte is loaded and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCeN | input | 1 | Host chip-enable, active low |
| hostOeN | input | 1 | Host output-enable / read strobe, active low |
| hostWeN | input | 1 | Host write strobe, active low |
| hostSel | input | 3 | Register select; bit 2 at 0 selects the address/ROM path |
| busIn | input | 8 | Data from the host bus |
| busOut | output | 8 | Data to the host bus |
| busOe | output | 1 | Enable for the bus driver |
| memAddr | output | 22 | Read address to the memory port |
| memData | input | 8 | Byte returned by the memory port, one clock after the address |

## Verification
The two functions that can coincide are the lane load caused by a write-strobe release and the auto-increment caused by an output-enable release. The bench provokes this by holding both strobes low during a ROM read and then releasing them on the same clock edge, so that both edges are detected in the same synchronised cycle. It then judges the result from the memory address port. The address must equal the previous upper bits with the new low byte, and it must not be that value plus one. The low lane is the only possible target, because the read has already cleared the pointer.

// File: rtl/seqAddrPort_pkg.sv
package seqAddrPort_pkg;
  localparam int LANE_PTR_W = 2;

  typedef struct packed {
    logic                  loadEn;
    logic [LANE_PTR_W-1:0] loadIdx;
    logic                  incEn;
  } ctlStrobe_t;
endpackage

// File: rtl/seqAddrCtl.sv
module seqAddrCtl
  import seqAddrPort_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_LAT     = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  oeN,
  input  logic                  weN,
  input  logic [2:0]            sel,
  output ctlStrobe_t            ctl,
  output logic                  ceSync,
  output logic                  selHi,
  output logic                  readWin,
  output logic [LANE_PTR_W-1:0] wrPtr
);
  localparam logic [LANE_PTR_W-1:0] LAST_LANE = LANE_PTR_W'(NUM_LAT - 1);

  logic [SYNC_STAGES-1:0] ceSh, oeSh, weSh;
  logic [2:0]             selSh [SYNC_STAGES];
  logic                   oePrev, wePrev;
  logic                   oeS, weS, active, weRise, oeRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSh   <= '1;
      oeSh   <= '1;
      weSh   <= '1;
      oePrev <= 1'b1;
      wePrev <= 1'b1;
      for (int k = 0; k < SYNC_STAGES; k++) selSh[k] <= 3'b000;
    end else begin
      ceSh     <= {ceSh[SYNC_STAGES-2:0], ceN};
      oeSh     <= {oeSh[SYNC_STAGES-2:0], oeN};
      weSh     <= {weSh[SYNC_STAGES-2:0], weN};
      selSh[0] <= sel;
      for (int k = 1; k < SYNC_STAGES; k++) selSh[k] <= selSh[k-1];
      oePrev   <= oeSh[SYNC_STAGES-1];
      wePrev   <= weSh[SYNC_STAGES-1];
    end
  end

  assign ceSync  = ceSh[SYNC_STAGES-1];
  assign oeS     = oeSh[SYNC_STAGES-1];
  assign weS     = weSh[SYNC_STAGES-1];
  assign selHi   = selSh[SYNC_STAGES-1][2];
  assign active  = !ceSync && !selHi;
  assign weRise  = weS && !wePrev;
  assign oeRise  = oeS && !oePrev;
  assign readWin = active && !oeS;

  // A write release beats a read release in the same cycle
  always_comb begin
    ctl.loadEn  = weRise && active;
    ctl.loadIdx = wrPtr;
    ctl.incEn   = oeRise && active && !ctl.loadEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           wrPtr <= '0;
    else if (ceSync || readWin)          wrPtr <= '0;
    else if (ctl.loadEn && wrPtr != LAST_LANE) wrPtr <= wrPtr + 1'b1;
  end
endmodule

// File: rtl/seqAddrDp.sv
module seqAddrDp
  import seqAddrPort_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              readWin,
  input  logic [BYTE_W-1:0] busIn,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] busOut,
  output logic              busOe
);
  logic [BYTE_W-1:0] dataSh [SYNC_STAGES];
  logic [ADDR_W-1:0] addrQ, loaded;
  logic              oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) dataSh[k] <= '0;
    end else begin
      dataSh[0] <= busIn;
      for (int k = 1; k < SYNC_STAGES; k++) dataSh[k] <= dataSh[k-1];
    end
  end

  // Each address bit takes its bus bit when its lane is the one selected
  for (genvar i = 0; i < ADDR_W; i++) begin : g_lane
    assign loaded[i] = (ctl.loadIdx == LANE_PTR_W'(i / BYTE_W))
                     ? dataSh[SYNC_STAGES-1][i % BYTE_W] : addrQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      oeQ   <= 1'b0;
    end else begin
      if (ctl.loadEn)     addrQ <= loaded;
      else if (ctl.incEn) addrQ <= addrQ + 1'b1;
      oeQ <= readWin;
    end
  end

  assign memAddr = addrQ;
  assign busOut  = memData;
  assign busOe   = oeQ;
endmodule

// File: rtl/seqAddrPort.sv
module seqAddrPort
  import seqAddrPort_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCeN,
  input  logic              hostOeN,
  input  logic              hostWeN,
  input  logic [2:0]        hostSel,
  input  logic [BYTE_W-1:0] busIn,
  output logic [BYTE_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memData
);
  localparam int NUM_LAT = (ADDR_W + BYTE_W - 1) / BYTE_W;

  ctlStrobe_t            ctl;
  logic                  ceSync, selHi, readWin;
  logic [LANE_PTR_W-1:0] wrPtr;

  seqAddrCtl #(.SYNC_STAGES(SYNC_STAGES), .NUM_LAT(NUM_LAT)) u_ctl (
    .clk(clk), .rstN(rstN), .ceN(hostCeN), .oeN(hostOeN), .weN(hostWeN),
    .sel(hostSel), .ctl(ctl), .ceSync(ceSync), .selHi(selHi),
    .readWin(readWin), .wrPtr(wrPtr)
  );

  seqAddrDp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .readWin(readWin), .busIn(busIn),
    .memData(memData), .memAddr(memAddr), .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/seqAddrPort_chk.sv
module seqAddrPort_chk
  import seqAddrPort_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int NUM_LAT = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input ctlStrobe_t            ctl,
  input logic                  ceSync,
  input logic                  selHi,
  input logic                  readWin,
  input logic [LANE_PTR_W-1:0] wrPtr,
  input logic [ADDR_W-1:0]     memAddr,
  input logic                  busOe
);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadEn && !ctl.incEn) |=> $stable(memAddr));

  p_page_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadEn && ctl.loadIdx == '0) |=> memAddr[ADDR_W-1:8] == $past(memAddr[ADDR_W-1:8]));

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    int'(wrPtr) < NUM_LAT);

  p_ptr_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    readWin |=> wrPtr == '0);

  p_ptr_desel_r7: assert property (@(posedge clk) disable iff (!rstN)
    ceSync |=> wrPtr == '0);

  p_ptr_io_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ceSync && selHi) |=> $stable(wrPtr));

  // R10: the sum is ADDR_W bits wide, so the top value wraps to zero
  p_inc_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incEn |=> memAddr == $past(memAddr) + 1'b1);

  p_bus_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    ceSync |=> !busOe);
endmodule

bind seqAddrPort seqAddrPort_chk #(.ADDR_W(ADDR_W), .NUM_LAT(NUM_LAT)) u_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .ceSync(ceSync), .selHi(selHi),
  .readWin(readWin), .wrPtr(wrPtr), .memAddr(memAddr), .busOe(busOe)
);

// File: tb/sim_seqAddrPort.sv
`timescale 1ns/1ps
module sim_seqAddrPort;
  logic clk = 1'b0, rstN = 1'b0;
  logic hostCeN = 1'b1, hostOeN = 1'b1, hostWeN = 1'b1;
  logic [2:0] hostSel = 3'b000;
  logic [7:0] busIn = 8'h00, busOut, memData;
  logic busOe;
  logic [21:0] memAddr;
  int total = 0, failed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seqAddrPort u0 (.clk(clk), .rstN(rstN), .hostCeN(hostCeN), .hostOeN(hostOeN),
    .hostWeN(hostWeN), .hostSel(hostSel), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .memAddr(memAddr), .memData(memData));

  function automatic logic [7:0] romByte(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) memData <= romByte(memAddr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCyc(input logic [2:0] s, input logic [7:0] d);
    hostSel = s; busIn = d; idle(2);
    hostWeN = 1'b0; idle(4);
    hostWeN = 1'b1; idle(6);
  endtask

  // Holds the read strobe low, samples the bus mid-pulse, then releases it
  task automatic rdCyc(input logic [2:0] s, output logic [7:0] b, output logic e);
    hostSel = s; idle(2);
    hostOeN = 1'b0; idle(6);
    b = busOut; e = busOe;
    hostOeN = 1'b1; idle(6);
  endtask

  // op: 0 address write, 1 ROM read, 2 I/O write, 3 I/O read
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 3'b000, 8'h34, 22'h000034},  // R1 R2 first write hits the low lane
    {2'd0, 3'b011, 8'h56, 22'h005634},  // R3 low select bits ignored
    {2'd0, 3'b001, 8'h07, 22'h075634},  // R2 top lane
    {2'd1, 3'b000, 8'h00, 22'h075635},  // R9
    {2'd1, 3'b010, 8'h00, 22'h075636},  // R3 R9
    {2'd0, 3'b000, 8'h3D, 22'h07563D},  // R5 R6 pointer back at low lane
    {2'd2, 3'b101, 8'hFF, 22'h07563D},  // R8 I/O write
    {2'd0, 3'b000, 8'h78, 22'h07783D},  // R8 load resumes at the middle lane
    {2'd3, 3'b110, 8'h00, 22'h07783D},  // R8 I/O read
    {2'd0, 3'b000, 8'h00, 22'h00783D},  // R2
    {2'd0, 3'b000, 8'h15, 22'h15783D},  // R4 pointer stays on top
    {2'd0, 3'b000, 8'hFF, 22'h3F783D}   // R4 upper bits dropped
  };

  initial begin
    logic [7:0] b;
    logic e;
    logic [21:0] keep;
    idle(3);
    check("R1 reset address", 32'(memAddr), 32'h0);
    check("R1 reset bus enable", 32'(busOe), 32'h0);
    check("R11 bus off while deselected", 32'(busOe), 32'h0);
    rstN = 1'b1; idle(2);
    hostCeN = 1'b0; idle(6);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][34:33])
        2'd0: wrCyc(VEC[i][32:30], VEC[i][29:22]);
        2'd1: begin
          rdCyc(VEC[i][32:30], b, e);
          check("R9 read bus enable", 32'(e), 32'h1);
          check("R9 read data", 32'(b), 32'(romByte(VEC[i][21:0] - 22'd1)));
        end
        2'd2: wrCyc(VEC[i][32:30], VEC[i][29:22]);
        default: begin
          rdCyc(VEC[i][32:30], b, e);
          check("R8 no drive on I/O read", 32'(e), 32'h0);
        end
      endcase
      check("R2 vector address", 32'(memAddr), 32'(VEC[i][21:0]));
    end

    check("R11 bus off with oe high", 32'(busOe), 32'h0);

    // R10: load all ones, then one read wraps the address
    rdCyc(3'b000, b, e);
    check("R6 read before reload", 32'(memAddr), 32'h3F783E);
    wrCyc(3'b000, 8'hFF); wrCyc(3'b000, 8'hFF); wrCyc(3'b000, 8'hFF);
    check("R4 all ones loaded", 32'(memAddr), 32'h3FFFFF);
    rdCyc(3'b000, b, e);
    check("R9 data at top address", 32'(b), 32'(romByte(22'h3FFFFF)));
    check("R10 wrap to zero", 32'(memAddr), 32'h0);

    // R12: strobes with chip-enable high are ignored
    hostCeN = 1'b1; idle(6);
    wrCyc(3'b000, 8'h99);
    check("R12 write ignored", 32'(memAddr), 32'h0);
    rdCyc(3'b000, b, e);
    check("R11 R12 bus off when deselected", 32'(e), 32'h0);
    check("R12 no increment when deselected", 32'(memAddr), 32'h0);
    hostCeN = 1'b0; idle(6);

    // R7: deselect clears a partial load
    wrCyc(3'b000, 8'h11);
    wrCyc(3'b000, 8'h22);
    check("R2 two-byte load", 32'(memAddr), 32'h002211);
    hostCeN = 1'b1; idle(6);
    hostCeN = 1'b0; idle(6);
    wrCyc(3'b000, 8'h33);
    check("R7 pointer back at low lane", 32'(memAddr), 32'h002233);

    // R13: write and read strobes released on the same edge
    keep = memAddr;
    hostSel = 3'b000; busIn = 8'hAB; idle(2);
    hostOeN = 1'b0; idle(6);
    hostWeN = 1'b0; idle(4);
    hostOeN = 1'b1; hostWeN = 1'b1; idle(8);
    check("R13 load wins over increment", 32'(memAddr), 32'({keep[21:8], 8'hAB}));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule